// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block converts single read and write requests from the chip into bus cycles on an external 64K x 8 asynchronous SRAM. The upper address byte always has its own dedicated output pins. A mode input chooses how the rest of the address and the data reach the memory. In multiplexed mode, one bidirectional 8-bit port carries the low address byte first and then the data. An address latch enable strobe makes an external transparent latch capture the low byte while the port still shows it. In non-multiplexed mode, the low address byte has its own pins, and the shared port carries only data.

Every access follows a fixed timing. After the request edge there is one latch-strobe cycle, one setup cycle, two cycles with the active-low read or write strobe asserted, one release cycle, and then a one-cycle done pulse. Only one access can be in progress at a time. The bidirectional port is split into three signals: an output value, an output enable and an input value. The pad combines them outside the block.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it ends, with no request, the outputs are as follows: `ext_rd_n`=1, `ext_wr_n`=1, `ext_ale`=0, `ext_ad_oe`=0, `acc_done`=0, `acc_rdata`=0 and `ext_hi_addr`=0.
- R2: An access begins on the first rising edge where `acc_req`=1 while the block is idle, and all inputs are captured on that edge. `mux_mode`=1 selects multiplexed mode. In this mode, during the cycle after the request edge, `ext_ale`=1 for exactly one cycle, `ext_ad_oe`=1 and `ext_ad_out` holds address bits [7:0].
- R3: With `mux_mode`=0, `ext_ale` stays 0 for the whole access and `ext_lo_addr` holds address bits [7:0] from the first access cycle until done. With `mux_mode`=1, `ext_lo_addr` is 0.
- R4: `ext_hi_addr` carries address bits [15:8] from the first access cycle onward and keeps that value until the next access starts.
- R5: In a write (`acc_wr`=1), `ext_ad_out` carries the write data with `ext_ad_oe`=1 from cycle 2 through cycle 5 after the request edge. `ext_wr_n`=0 in cycles 3 and 4 only, so the data is stable before the strobe falls and after it rises.
- R6: In a read (`acc_wr`=0), the port is released (`ext_ad_oe`=0) from cycle 2 onward, and `ext_rd_n`=0 in cycles 3 and 4 only. The port is never driven while `ext_rd_n`=0.
- R7: In a read, `ext_ad_in` is captured on the last edge before `ext_rd_n` rises. From then on, `acc_rdata` shows it until the next read completes, and writes leave it unchanged.
- R8: `acc_done` is high for exactly one cycle, in cycle 6 after the request edge.
- R9: Requests and input changes between the request edge and the done cycle, including the done cycle itself, are ignored. The access uses the captured values, and the cycle after done is idle.
- R10: `ext_rd_n` and `ext_wr_n` are never low together, and only the strobe matching the captured direction is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_mode | input | 1 | 1 = shared address/data port, 0 = separate low address pins |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Data from the last completed read |
| acc_done | output | 1 | One-cycle completion pulse |
| ext_hi_addr | output | 8 | Upper address byte to the SRAM |
| ext_lo_addr | output | 8 | Low address byte in non-multiplexed mode |
| ext_ale | output | 1 | Address latch enable for the external latch |
| ext_ad_out | output | 8 | Value driven on the shared port |
| ext_ad_oe | output | 1 | Output enable for the shared port |
| ext_ad_in | input | 8 | Value read from the shared port |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
The bench contains its own transparent latch and SRAM. A wrong phase in the sequencer therefore shows up within the same access: the latch captures the wrong address, the memory gets a write at a corrupt location, or a strobe lasts the wrong number of cycles. Every access is also checked cycle by cycle for its done timing, its ALE count and bus contention. Stale captured state shows up when the data is read back in the opposite mode. A missed or extra acceptance shows up one cycle after done as non-idle pins.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LATCH  = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_DONE   = 3'd5
    } xm_state_e;
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic              mux_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output xm_state_e         nxt_st,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [DATA_W-1:0] nxt_wdata,
    output logic              nxt_wr,
    output logic              nxt_mux,
    output logic              rd_sample
);
    localparam int CNT_W = $clog2(STB_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CYC - 1);

    typedef struct packed {
        xm_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              mux;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (req) begin
                    seq_d.st    = ST_LATCH;
                    seq_d.addr  = addr;
                    seq_d.wdata = wdata;
                    seq_d.wr    = wr;
                    seq_d.mux   = mux_mode;
                end
            end
            ST_LATCH: seq_d.st = ST_SETUP;
            ST_SETUP: begin
                seq_d.st  = ST_STROBE;
                seq_d.cnt = '0;
            end
            ST_STROBE: begin
                if (seq_q.cnt == CNT_LAST) seq_d.st = ST_HOLD;
                else seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_HOLD: seq_d.st = ST_DONE;
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign nxt_st    = seq_d.st;
    assign nxt_addr  = seq_d.addr;
    assign nxt_wdata = seq_d.wdata;
    assign nxt_wr    = seq_d.wr;
    assign nxt_mux   = seq_d.mux;
    assign rd_sample = (seq_q.st == ST_STROBE) && (seq_q.cnt == CNT_LAST) && !seq_q.wr;

    // R9: captured request fields do not move while an access is in flight
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |=> $stable({seq_q.addr, seq_q.wdata, seq_q.wr, seq_q.mux}));
endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xm_state_e                nxt_st,
    input  logic [ADDR_W-1:0]        nxt_addr,
    input  logic [DATA_W-1:0]        nxt_wdata,
    input  logic                     nxt_wr,
    input  logic                     nxt_mux,
    input  logic                     rd_sample,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_addr,
    output logic [DATA_W-1:0]        lo_addr,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic              ale;
        logic [DATA_W-1:0] ad;
        logic              oe;
        logic              rd_n;
        logic              wr_n;
        logic              done;
        logic              mux;
        logic [DATA_W-1:0] rdata;
    } pin_t;

    pin_t pin_q, pin_d;

    always_comb begin
        pin_d       = pin_q;
        pin_d.ale   = 1'b0;
        pin_d.ad    = '0;
        pin_d.oe    = 1'b0;
        pin_d.rd_n  = 1'b1;
        pin_d.wr_n  = 1'b1;
        pin_d.done  = 1'b0;
        if (rd_sample) pin_d.rdata = ad_in;
        if (nxt_st != ST_IDLE) begin
            pin_d.hi  = nxt_addr[ADDR_W-1:DATA_W];
            pin_d.lo  = nxt_mux ? '0 : nxt_addr[DATA_W-1:0];
            pin_d.mux = nxt_mux;
        end
        case (nxt_st)
            ST_LATCH: begin
                if (nxt_mux) begin
                    pin_d.ale = 1'b1;
                    pin_d.oe  = 1'b1;
                    pin_d.ad  = nxt_addr[DATA_W-1:0];
                end else begin
                    pin_d.oe = nxt_wr;
                    pin_d.ad = nxt_wr ? nxt_wdata : '0;
                end
            end
            ST_SETUP, ST_HOLD: begin
                pin_d.oe = nxt_wr;
                pin_d.ad = nxt_wr ? nxt_wdata : '0;
            end
            ST_STROBE: begin
                pin_d.oe   = nxt_wr;
                pin_d.ad   = nxt_wr ? nxt_wdata : '0;
                pin_d.rd_n = nxt_wr;
                pin_d.wr_n = !nxt_wr;
            end
            ST_DONE: pin_d.done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q      <= '0;
            pin_q.rd_n <= 1'b1;
            pin_q.wr_n <= 1'b1;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign hi_addr = pin_q.hi;
    assign lo_addr = pin_q.lo;
    assign ale     = pin_q.ale;
    assign ad_out  = pin_q.ad;
    assign ad_oe   = pin_q.oe;
    assign rd_n    = pin_q.rd_n;
    assign wr_n    = pin_q.wr_n;
    assign done    = pin_q.done;
    assign rdata   = pin_q.rdata;

    // R2: latch strobe lasts one cycle and the port is driven while it is high
    p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe ##1 !ale);
    // R3: no latch strobe in non-multiplexed mode
    p_ale_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_q.mux |-> !ale);
    // R5: write data driven and stable during the write strobe
    p_wr_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe && $stable(ad_out));
    // R5: data still driven on the cycle the write strobe rises
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);
    // R6: port released while the memory drives it
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: the two strobes are never low together
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int STB_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mux_mode,
    input  logic                     acc_req,
    input  logic                     acc_wr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [DATA_W-1:0]        acc_wdata,
    output logic [DATA_W-1:0]        acc_rdata,
    output logic                     acc_done,
    output logic [ADDR_W-DATA_W-1:0] ext_hi_addr,
    output logic [DATA_W-1:0]        ext_lo_addr,
    output logic                     ext_ale,
    output logic [DATA_W-1:0]        ext_ad_out,
    output logic                     ext_ad_oe,
    input  logic [DATA_W-1:0]        ext_ad_in,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n
);
    xm_state_e         nxt_st;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] nxt_wdata;
    logic              nxt_wr;
    logic              nxt_mux;
    logic              rd_sample;

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_CYC(STB_CYC)) seq_i (
        .clk(clk), .rst_n(rst_n), .req(acc_req), .wr(acc_wr), .mux_mode(mux_mode),
        .addr(acc_addr), .wdata(acc_wdata), .nxt_st(nxt_st), .nxt_addr(nxt_addr),
        .nxt_wdata(nxt_wdata), .nxt_wr(nxt_wr), .nxt_mux(nxt_mux), .rd_sample(rd_sample)
    );

    xmem_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pin_i (
        .clk(clk), .rst_n(rst_n), .nxt_st(nxt_st), .nxt_addr(nxt_addr),
        .nxt_wdata(nxt_wdata), .nxt_wr(nxt_wr), .nxt_mux(nxt_mux), .rd_sample(rd_sample),
        .ad_in(ext_ad_in), .hi_addr(ext_hi_addr), .lo_addr(ext_lo_addr), .ale(ext_ale),
        .ad_out(ext_ad_out), .ad_oe(ext_ad_oe), .rd_n(ext_rd_n), .wr_n(ext_wr_n),
        .done(acc_done), .rdata(acc_rdata)
    );
endmodule

// File: tb/xmem_bus_ctrl_tb.sv
module xmem_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mux_mode = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        acc_done;
    logic [7:0]  ext_hi_addr, ext_lo_addr, ext_ad_out;
    logic        ext_ale, ext_ad_oe, ext_rd_n, ext_wr_n;
    logic [7:0]  ext_ad_in = 8'hFF;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit armed = 0;

    always #10 clk = ~clk;

    xmem_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_done(acc_done),
        .ext_hi_addr(ext_hi_addr), .ext_lo_addr(ext_lo_addr), .ext_ale(ext_ale),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    // External transparent latch, open while the strobe is high
    logic [7:0] lat_q = 8'h00;
    logic       tb_mux = 1'b0;
    always @(negedge clk) if (ext_ale) lat_q = ext_ad_out;

    // External SRAM model
    logic [7:0] sram [int];
    function automatic int sram_addr();
        return tb_mux ? {ext_hi_addr, lat_q} : {ext_hi_addr, ext_lo_addr};
    endfunction
    function automatic logic [7:0] sram_peek(int a);
        return sram.exists(a) ? sram[a] : 8'h00;
    endfunction
    always @(posedge ext_wr_n) if (armed) sram[sram_addr()] = ext_ad_out;
    always @(negedge ext_rd_n) if (armed) ext_ad_in = sram_peek(sram_addr());
    always @(posedge ext_rd_n) ext_ad_in = 8'hFF;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(int i);
        if (i == 64) return 16'h0000;
        if (i == 65) return 16'hFFFF;
        return 16'(i * 16'h0A37) ^ 16'hC3A5;
    endfunction
    function automatic logic [7:0] data_of(int i, int p);
        return 8'(i * 37 + p * 101 + 5);
    endfunction

    logic [7:0] last_rd = 8'h00;

    task automatic access(input bit m, input bit w, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] exp_rd);
        int ale_cnt = 0, rd_cnt = 0, wr_cnt = 0, clash = 0;
        @(negedge clk);
        tb_mux = m; mux_mode = m; acc_wr = w; acc_addr = a; acc_wdata = d; acc_req = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (c == 1) begin
                // R9: scramble inputs while busy, request held high
                acc_addr = ~a; acc_wdata = ~d; acc_wr = ~w; mux_mode = ~m;
                if (m) chk(ext_ad_out == a[7:0] && ext_ad_oe, "R2 low address on port",
                           ext_ad_out, a[7:0]);
            end
            if (ext_ale) ale_cnt++;
            if (!ext_rd_n) rd_cnt++;
            if (!ext_wr_n) wr_cnt++;
            if (!ext_rd_n && ext_ad_oe) clash++;
            if (c == 2 && w) chk(ext_ad_oe && ext_ad_out == d, "R5 data before strobe",
                                 ext_ad_out, d);
            if (c == 3) begin
                chk(ext_hi_addr == a[15:8], "R4 upper address", ext_hi_addr, a[15:8]);
                chk(ext_lo_addr == (m ? 8'h00 : a[7:0]), "R3 low address pins",
                    ext_lo_addr, m ? 8'h00 : a[7:0]);
            end
            if (c == 5 && w) chk(ext_ad_oe && ext_ad_out == d, "R5 data after strobe",
                                 ext_ad_out, d);
            if (c < 6) chk(!acc_done, "R8 early done", acc_done, 0);
        end
        chk(acc_done, "R8 done in cycle 6", acc_done, 1);
        chk(ale_cnt == (m ? 1 : 0), m ? "R2 one latch strobe" : "R3 no latch strobe",
            ale_cnt, m ? 1 : 0);
        chk(rd_cnt == (w ? 0 : 2) && wr_cnt == (w ? 2 : 0), "R10 strobe selection/length",
            {rd_cnt[7:0], wr_cnt[7:0]}, w ? 2 : 16'h0200);
        chk(clash == 0, "R6 no drive under read strobe", clash, 0);
        if (m) chk(lat_q == a[7:0], "R2 latch captured low address", lat_q, a[7:0]);
        if (!w) begin
            chk(acc_rdata == exp_rd, "R7 read data", acc_rdata, exp_rd);
            last_rd = exp_rd;
        end else begin
            chk(acc_rdata == last_rd, "R7 read data held over write", acc_rdata, last_rd);
        end
        @(negedge clk);
        chk(ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && !acc_done,
            "R9 idle after done despite request",
            {ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe, acc_done}, 5'b11000);
        acc_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && !acc_done,
            "R1 strobes in reset", {ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe, acc_done}, 5'b11000);
        rst_n = 1'b1;
        armed = 1'b1;
        repeat (2) @(negedge clk);
        chk(acc_rdata == 8'h00 && ext_hi_addr == 8'h00 && ext_rd_n && ext_wr_n && !ext_ale,
            "R1 idle after reset", {acc_rdata, ext_hi_addr}, 0);
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 66; i++)
                access(p[0], 1'b1, addr_of(i), data_of(i, p), 8'h00);
            for (int i = 0; i < 66; i++)
                access(~p[0], 1'b0, addr_of(i), 8'h00, data_of(i, p));
            for (int i = 0; i < 66; i += 13)
                access(p[0], 1'b0, addr_of(i), 8'h00, data_of(i, p));
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule